// File: doc/BRIEF.md
# SPI Master Rate Divider and Automatic Select

This block runs single-byte SPI transfers as a bus master. The serial clock comes from a divider of the system (bus) clock. The divider has two programmable stages. A 3-bit prescale field gives an integer multiplier from 1 to 8. A 3-bit exponent field gives a power of two from 2 to 256. Their product sets the serial clock period. This makes rates such as divide-by-6 or divide-by-10 reachable, as well as the plain powers of two. The divider counter runs only while a transfer is in progress. At all other times it is held at zero.

Software-side logic starts a transfer by pulsing a write strobe with one byte of data while the block is idle in master mode. The byte is shifted out MSB first in clock mode 0: the clock idles low, the master changes its output on the falling edge, and the input line is sampled on the rising edge. When the eighth bit completes, the received byte appears on the read-data port and a done flag pulses.

The block can drive the slave-select pin by itself. This only happens in master mode with both the select-drive enable and the fault-check enable set. In that case the pin is low for the whole transfer and high while idle, and fault checking is masked. With fault checking enabled and automatic select off, a low level on the select input is a mode fault. A mode fault aborts the transfer and takes the block out of master mode until the master enable is dropped.

Top module: `spi_baud_master`

## Requirements
- R1: One serial clock period lasts D = (P+1)·2^(E+1) clock cycles, where P is `rate_pre` and E is `rate_exp`, both read as unsigned binary. Each level of `sck` lasts D/2 cycles. The done flag is observed exactly 8·D cycles after the clock edge that accepts the strobe.
- R2: With both rate fields zero, D is 2, so a whole transfer takes 16 cycles.
- R3: The divider counter is held at zero whenever no transfer runs. Every transfer therefore starts with a full first half-period, whatever time has passed since the last one.
- R4: A transfer sends `wr_data` MSB first on `mosi` during exactly 8 rising edges of `sck`. `mosi` changes only when `sck` falls, and `sck` is low when idle and when done is raised.
- R5: `miso` is sampled on each rising `sck` edge, MSB first. The assembled byte appears on `rd_data` together with `done`, and `done` is high for exactly one clock cycle.
- R6: A write strobe that arrives while a transfer runs is ignored. It neither changes the byte being sent nor starts a further transfer.
- R7: Rate field changes during a transfer do not alter its timing. They apply from the next transfer on.
- R8: `ss_oe` is 1 only when `master_en`, `ss_auto_en` and `fault_en` are all 1 and no fault is pending. In that case `ss_out` is 0 while a transfer runs and 1 otherwise. When `ss_oe` is 0, `ss_out` is 1.
- R9: With master mode on, `fault_en` = 1, `ss_auto_en` = 0 and `ss_in` low at a clock edge, `fault` is 1 from that edge on. The running transfer stops with `sck` low and no done. Strobes then start nothing until `master_en` is 0 at a clock edge, which clears `fault`.
- R10: While the automatic select output is active, a low `ss_in` never raises `fault`.
- R11: After reset, `sck`, `ss_oe`, `done`, `fault` and `rd_data` are 0 and `ss_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_pre | input | 3 | Prescale field P, multiplier P+1 |
| rate_exp | input | 3 | Exponent field E, factor 2^(E+1) |
| master_en | input | 1 | Master mode request |
| ss_auto_en | input | 1 | Request to drive the select pin automatically |
| fault_en | input | 1 | Mode-fault check enable |
| wr_stb | input | 1 | One-cycle start strobe |
| wr_data | input | 8 | Byte to send |
| miso | input | 1 | Serial input from the slave |
| ss_in | input | 1 | Select pin input level |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial output to the slave |
| ss_out | output | 1 | Select pin output level |
| ss_oe | output | 1 | Select pin output enable |
| rd_data | output | 8 | Last received byte |
| done | output | 1 | One-cycle transfer-complete pulse |
| fault | output | 1 | Mode fault pending |

## Verification
The assertions assume that `miso` and `ss_in` are already synchronous to `clk`. They also assume the strobe is a single-cycle pulse, and that the slave moves `miso` only after a falling `sck`. The bench drives every input right after a falling clock edge. Its slave model changes `miso` only in response to a falling `sck`. It raises `ss_in` low only in the fault and automatic-select scenarios, and it clears the master enable before reusing the block after a fault.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int PRE_W  = 3;
  localparam int SEL_W  = 3;
  // half period (P+1)*2^E needs PRE_W + 2^SEL_W bits at most
  localparam int HALF_W = PRE_W + (1 << SEL_W);

  // Bus clocks per SCK level: (P+1) * 2^E, i.e. half of the full divisor.
  function automatic logic [HALF_W-1:0] half_period(
    input logic [PRE_W-1:0] pre,
    input logic [SEL_W-1:0] sel
  );
    logic [HALF_W-1:0] base;
    base = HALF_W'(pre) + HALF_W'(1);
    return base << sel;
  endfunction
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div
  import spi_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              tick_o,
  output logic [HALF_W-1:0] half_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_q;
  logic              at_limit;

  assign at_limit = (cnt_q == half_q - HALF_W'(1));
  assign tick_o   = run_i & at_limit;
  assign half_o   = half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= HALF_W'(1);
    end else if (load_i) begin
      half_q <= half_period(pre_i, sel_i);
      cnt_q  <= '0;
    end else if (run_i) begin
      cnt_q  <= at_limit ? '0 : cnt_q + HALF_W'(1);
    end else begin
      cnt_q  <= '0;
    end
  end

  AST_DIV_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0); // R3
  AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_q); // R1
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              miso_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              load_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  logic              busy_q, sck_q, done_q;
  logic [DATA_W-1:0] tx_q, rx_q, rdata_q;
  logic [BCW-1:0]    bit_q;
  logic              start_ok, rise_ev, fall_ev, last_fall;

  assign start_ok  = master_i & ~busy_q & start_i;
  assign rise_ev   = busy_q & tick_i & ~sck_q;
  assign fall_ev   = busy_q & tick_i &  sck_q;
  assign last_fall = fall_ev & (bit_q == LAST_BIT);

  assign busy_o  = busy_q;
  assign load_o  = start_ok;
  assign sck_o   = sck_q;
  assign mosi_o  = tx_q[DATA_W-1];
  assign rdata_o = rdata_q;
  assign done_o  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      bit_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!master_i) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
      end else if (start_ok) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        tx_q   <= wdata_i;
        bit_q  <= '0;
      end else if (rise_ev) begin
        sck_q <= 1'b1;
        rx_q  <= {rx_q[DATA_W-2:0], miso_i};
      end else if (fall_ev) begin
        sck_q <= 1'b0;
        if (last_fall) begin
          busy_q  <= 1'b0;
          rdata_q <= rx_q;
          done_q  <= 1'b1;
        end else begin
          bit_q <= bit_q + BCW'(1);
          tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && $past(master_i) && (sck_q != $past(sck_q))) |-> $past(tick_i)); // R1
  AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(fall_ev)) |-> $stable(mosi_o)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5
  AST_DONE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !sck_q && !busy_q); // R4
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |=> !busy_q && !sck_q); // R9
endmodule

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en_i,
  input  logic ss_auto_en_i,
  input  logic fault_en_i,
  input  logic ss_in_i,
  input  logic busy_i,
  output logic master_o,
  output logic ss_out_o,
  output logic ss_oe_o,
  output logic fault_o
);
  logic fault_q;
  logic auto_ss, fault_hit;

  assign master_o  = master_en_i & ~fault_q;
  assign auto_ss   = master_o & ss_auto_en_i & fault_en_i;
  assign fault_hit = master_o & fault_en_i & ~ss_auto_en_i & ~ss_in_i;
  assign ss_oe_o   = auto_ss;
  assign ss_out_o  = ~(auto_ss & busy_i);
  assign fault_o   = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            fault_q <= 1'b0;
    else if (!master_en_i) fault_q <= 1'b0;
    else if (fault_hit)    fault_q <= 1'b1;
  end

  AST_SS_OE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    ss_oe_o |-> master_en_i && ss_auto_en_i && fault_en_i && !fault_q); // R8
  AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ss_oe_o |=> !$rose(fault_q)); // R10
  AST_FAULT_STOPS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_q) && fault_q |-> !busy_i); // R9
  AST_SS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> ss_out_o); // R8
endmodule

// File: rtl/spi_baud_master.sv
module spi_baud_master
  import spi_rate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  rate_pre,
  input  logic [SEL_W-1:0]  rate_exp,
  input  logic              master_en,
  input  logic              ss_auto_en,
  input  logic              fault_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              miso,
  input  logic              ss_in,
  output logic              sck,
  output logic              mosi,
  output logic              ss_out,
  output logic              ss_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              fault
);
  logic              master_w, busy_w, load_w, tick_w;
  logic [HALF_W-1:0] half_w;

  spi_ss_ctrl u_ss (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_en_i  (master_en),
    .ss_auto_en_i (ss_auto_en),
    .fault_en_i   (fault_en),
    .ss_in_i      (ss_in),
    .busy_i       (busy_w),
    .master_o     (master_w),
    .ss_out_o     (ss_out),
    .ss_oe_o      (ss_oe),
    .fault_o      (fault)
  );

  spi_rate_div u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .run_i  (busy_w),
    .pre_i  (rate_pre),
    .sel_i  (rate_exp),
    .tick_o (tick_w),
    .half_o (half_w)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .master_i (master_w),
    .start_i  (wr_stb),
    .wdata_i  (wr_data),
    .miso_i   (miso),
    .tick_i   (tick_w),
    .busy_o   (busy_w),
    .load_o   (load_w),
    .sck_o    (sck),
    .mosi_o   (mosi),
    .rdata_o  (rd_data),
    .done_o   (done)
  );

  AST_HALF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(half_w)); // R7
  AST_STROBE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && wr_stb) |-> !load_w); // R6
endmodule

// File: tb/sim_spi_baud_master.sv
module sim_spi_baud_master;
  localparam int CLK_P = 10;
  localparam int WDOG  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_pre = '0, rate_exp = '0;
  logic       master_en = 1'b0, ss_auto_en = 1'b0, fault_en = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       miso;
  logic       ss_in = 1'b1;
  logic       sck, mosi, ss_out, ss_oe, done, fault;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  int rise_cnt = 0, fall_cnt = 0, fall_base = 0, done_cnt = 0;
  logic [7:0] cap = '0;
  logic [7:0] slave_byte = '0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_baud_master u0 (
    .clk(clk), .rst_n(rst_n), .rate_pre(rate_pre), .rate_exp(rate_exp),
    .master_en(master_en), .ss_auto_en(ss_auto_en), .fault_en(fault_en),
    .wr_stb(wr_stb), .wr_data(wr_data), .miso(miso), .ss_in(ss_in),
    .sck(sck), .mosi(mosi), .ss_out(ss_out), .ss_oe(ss_oe),
    .rd_data(rd_data), .done(done), .fault(fault)
  );

  // slave model: next bit presented after each falling SCK
  always_comb begin
    int k;
    k = fall_cnt - fall_base;
    miso = (k >= 0 && k < 8) ? slave_byte[7-k] : 1'b0;
  end
  always @(posedge sck) begin cap = {cap[6:0], mosi}; rise_cnt++; end
  always @(negedge sck) fall_cnt++;
  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int divisor(input int p, input int e);
    return (p + 1) * (2 ** (e + 1));
  endfunction

  // mid_kind: 0 none, 1 extra strobe, 2 zero the rate fields, 3 select-pin probe
  task automatic xfer(input int p, input int e, input logic [7:0] data,
                      input logic [7:0] sb, input int exp_cyc, input string tag,
                      input int mid_at, input int mid_kind);
    int n, rb, db;
    rate_pre = 3'(p); rate_exp = 3'(e);
    slave_byte = sb; fall_base = fall_cnt;
    rb = rise_cnt; db = done_cnt;
    @(negedge clk); wr_stb = 1'b1; wr_data = data;
    @(negedge clk); wr_stb = 1'b0;
    n = 0;
    while (!done && n < 40000) begin
      @(negedge clk); n++;
      wr_stb = 1'b0;
      if (n == mid_at) begin
        case (mid_kind)
          1: begin wr_stb = 1'b1; wr_data = ~data; end
          2: begin rate_pre = '0; rate_exp = '0; end
          3: begin
               chk("R8 ss_out low in transfer", int'(ss_out), 0);
               chk("R8 ss_oe on", int'(ss_oe), 1);
               chk("R10 no fault", int'(fault), 0);
             end
          default: ;
        endcase
      end
    end
    chk({tag, " cycles strobe to done"}, n, exp_cyc);
    chk("R4 rising edges", rise_cnt - rb, 8);
    chk("R4 mosi byte", int'(cap), int'(data));
    chk("R5 rd_data", int'(rd_data), int'(sb));
    chk("R4 sck low at done", int'(sck), 0);
    @(negedge clk);
    chk("R5 done one cycle", int'(done), 0);
    chk("R5 single done", done_cnt - db, 1);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 sck", int'(sck), 0);
    chk("R11 ss_oe", int'(ss_oe), 0);
    chk("R11 ss_out", int'(ss_out), 1);
    chk("R11 done", int'(done), 0);
    chk("R11 fault", int'(fault), 0);
    chk("R11 rd_data", int'(rd_data), 0);
    master_en = 1'b1;
    @(negedge clk);

    // default rate
    xfer(0, 0, 8'hA5, 8'h3C, 16, "R2", 0, 0);

    // sweep prescale x exponent (exponent 0..5)
    for (int p = 0; p < 8; p++)
      for (int e = 0; e < 6; e++) begin
        logic [7:0] d, s;
        d = 8'((p * 37 + e * 11 + 5) & 255);
        s = 8'(~d ^ 8'(p << 4));
        repeat (p + e) @(negedge clk); // idle gaps of varied length (R3)
        xfer(p, e, d, s, 8 * divisor(p, e), "R1 R3", 0, 0);
      end
    // largest exponents at both prescale extremes
    xfer(0, 6, 8'h81, 8'h7E, 8 * divisor(0, 6), "R1", 0, 0);
    xfer(7, 6, 8'h01, 8'h80, 8 * divisor(7, 6), "R1", 0, 0);
    xfer(0, 7, 8'hFF, 8'h00, 8 * divisor(0, 7), "R1", 0, 0);
    xfer(7, 7, 8'h00, 8'hFF, 8 * divisor(7, 7), "R1", 0, 0);

    // strobe during transfer ignored
    begin
      int rb;
      xfer(1, 1, 8'h5A, 8'hC3, 8 * divisor(1, 1), "R6", 20, 1);
      rb = rise_cnt;
      repeat (100) @(negedge clk);
      chk("R6 no second transfer", rise_cnt - rb, 0);
    end

    // rate change mid transfer applies next time
    xfer(1, 1, 8'h96, 8'h69, 8 * divisor(1, 1), "R7", 10, 2);
    xfer(int'(rate_pre), int'(rate_exp), 8'h33, 8'hCC, 16, "R7", 0, 0);

    // automatic select output
    ss_auto_en = 1'b1; fault_en = 1'b0;
    @(negedge clk);
    chk("R8 ss_oe off without fault_en", int'(ss_oe), 0);
    chk("R8 ss_out high when not driven", int'(ss_out), 1);
    fault_en = 1'b1; ss_in = 1'b0;
    @(negedge clk);
    chk("R8 ss_oe on", int'(ss_oe), 1);
    chk("R8 ss_out high idle", int'(ss_out), 1);
    xfer(2, 1, 8'hE7, 8'h18, 8 * divisor(2, 1), "R8", 15, 3);
    chk("R8 ss_out high after done", int'(ss_out), 1);
    chk("R10 no fault after transfer", int'(fault), 0);

    // mode fault
    ss_in = 1'b1; ss_auto_en = 1'b0; fault_en = 1'b1;
    rate_pre = 3'd0; rate_exp = 3'd2;
    @(negedge clk);
    chk("R8 ss_oe off without auto", int'(ss_oe), 0);
    begin
      int rb, db;
      db = done_cnt;
      wr_stb = 1'b1; wr_data = 8'h77;
      @(negedge clk); wr_stb = 1'b0;
      repeat (10) @(negedge clk);
      ss_in = 1'b0;
      @(negedge clk);
      chk("R9 fault raised", int'(fault), 1);
      chk("R9 sck low after abort", int'(sck), 0);
      rb = rise_cnt;
      repeat (100) @(negedge clk);
      chk("R9 aborted no done", done_cnt - db, 0);
      chk("R9 no edges after abort", rise_cnt - rb, 0);
      wr_stb = 1'b1;
      @(negedge clk); wr_stb = 1'b0;
      repeat (100) @(negedge clk);
      chk("R9 strobe ignored in fault", rise_cnt - rb, 0);
      chk("R9 fault held", int'(fault), 1);
      ss_in = 1'b1; master_en = 1'b0;
      @(negedge clk);
      chk("R9 fault cleared", int'(fault), 0);
      master_en = 1'b1; fault_en = 1'b0;
      @(negedge clk);
    end
    xfer(0, 0, 8'h42, 8'hBD, 16, "R9 recovery", 0, 0);

    summary();
  end
endmodule